// File: doc/BRIEF.md
# UART Byte FIFO Pair with Ready-Line Generation

This block holds the transmit and receive byte queues of one UART channel and drives two active-low ready lines, `rxrdy_n` and `txrdy_n`, that a transfer agent watches to decide when to move data. The serial side feeds received bytes in through a valid/ready stream and takes bytes to send out through a second valid/ready stream. A host writes transmit bytes and reads received bytes with single-cycle strobes. A small control word selects whether the queues are enabled, whether the ready lines follow single-character rules or block-transfer rules, and which of four receive trigger levels is used.

When the queues are disabled, each side behaves as a one-byte holding register. When they are enabled in single-character mode, the ready lines report "any data" on the receive side and "completely empty" on the transmit side. In block mode, `rxrdy_n` asserts once enough bytes are queued (or a receive timeout pulse arrives) and stays asserted until the receive queue is drained, while `txrdy_n` stays asserted as long as any free slot remains. A control write takes effect on the next clock.

Stream rules: `rxs_ready` is high while the receive queue has space, and a byte is taken on a clock where `rxs_valid` and `rxs_ready` are both high. `txs_valid` is high while the transmit queue holds a byte, `txs_data` shows the oldest byte, and it is removed on a clock where `txs_ready` is also high. A source that sees `rxs_ready` low must hold its byte. A byte accepted in the same cycle as a clear of its queue is discarded.

Top module: `uart_fifo_rdy`

## Requirements
- R1: After reset both queues are empty, the queues are disabled, single-character rules apply, `rxrdy_n` = 1, `txrdy_n` = 0, `rxs_ready` = 1, `txs_valid` = 0, and both error flags are 0.
- R2: With the queues disabled (control bit 0 = 0) each side holds at most one byte; `rxrdy_n` is 0 exactly while a received byte is held, `txrdy_n` is 1 exactly while a transmit byte is held, and `rxs_ready` is 0 while the receive byte is held.
- R3: With the queues enabled (bit 0 = 1) and block mode off (bit 3 = 0), `rxrdy_n` is 0 exactly while the receive queue holds at least one byte, and `txrdy_n` is 0 exactly while the transmit queue is completely empty.
- R4: In block mode (bits 0 and 3 both 1), `rxrdy_n` falls once the receive count is at or above the trigger level chosen by control bits 5:4 (00 = 8, 01 = 16, 10 = 56, 11 = 60 bytes), then stays 0 while bytes are read out and returns to 1 only when the receive queue is empty.
- R5: In block mode a one-cycle `rx_timeout` pulse while the receive queue is not empty makes `rxrdy_n` 0 after that clock, even below the trigger level.
- R6: In block mode `txrdy_n` is 0 while the transmit queue has at least one free slot of its 128 and 1 when it is full.
- R7: A control write with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue; a write that changes bit 0 empties both. After that clock the ready lines show their empty-queue values.
- R8: A host write while the transmit queue is full (1 byte when disabled, 128 when enabled) stores nothing and sets `err_tx_ovf`, which stays 1 until reset.
- R9: A host read while the receive queue is empty changes nothing and sets `err_rx_unf`, which stays 1 until reset.
- R10: Bytes leave each queue in the order they entered; the enabled capacity is 128 bytes per queue, and `rxs_ready` / `txs_valid` follow the space and occupancy of their queues.
- R11: Control writes act from the next clock; on entering block mode the receive hold state is cleared, so `rxrdy_n` is 1 in the first block-mode cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_data | input | 6 | Control word: bit0 enable, bit1 clear receive, bit2 clear transmit, bit3 block mode, bits 5:4 trigger select |
| host_wr | input | 1 | Host transmit byte write strobe |
| host_wdata | input | 8 | Host transmit byte |
| host_rd | input | 1 | Host receive byte read strobe |
| host_rdata | output | 8 | Oldest received byte (meaningful while the receive queue is not empty) |
| rxs_valid | input | 1 | Received byte offered by the serial side |
| rxs_data | input | 8 | Received byte |
| rxs_ready | output | 1 | Receive queue has space |
| txs_valid | output | 1 | Transmit queue holds a byte |
| txs_data | output | 8 | Oldest transmit byte |
| txs_ready | input | 1 | Serial side takes the transmit byte |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| rxrdy_n | output | 1 | Active-low receive ready line |
| txrdy_n | output | 1 | Active-low transmit ready line |
| err_tx_ovf | output | 1 | Sticky flag: host wrote into a full transmit queue |
| err_rx_unf | output | 1 | Sticky flag: host read from an empty receive queue |

## Verification
The hardest situation to reach is the block-mode hold on `rxrdy_n` at the two upper trigger levels combined with mode changes: the receive queue must be filled to 56 or 60 bytes, then drained while the line must stay low, and the mode must be left and re-entered with bytes still queued to show the hold state was cleared. Directed phases fill the queue to one below each trigger and then one more, drain it to a single byte and then to empty, and toggle between single-character and block mode with three bytes present. A long random phase then mixes pushes, reads, drains, timeouts and occasional control writes, while a queue-based reference model is compared against every output on every clock.

// File: rtl/uart_rdy_pkg.sv
`timescale 1ns/1ps
package uart_rdy_pkg;

  localparam int CFG_W        = 6;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_CLRRX_BIT = 1;
  localparam int CFG_CLRTX_BIT = 2;
  localparam int CFG_BLK_BIT  = 3;
  localparam int CFG_TRG_LSB  = 4;

  typedef struct packed {
    logic [1:0] trig_sel;
    logic       blk;
    logic       en;
  } rdy_cfg_t;

  // receive trigger level in bytes for each select code
  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 56;
      default: return 60;
    endcase
  endfunction

endpackage

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          clr,
  output logic [DW-1:0] head,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt >= cap);
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_comb begin
    if (clr) cnt_nxt = '0;
    else     cnt_nxt = cnt + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= bump(wr_ptr);
        if (pop_ok)  rd_ptr <= bump(rd_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/rdy_ctrl.sv
`timescale 1ns/1ps
module rdy_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          blk,
  input  logic [CW-1:0] trig,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] rx_cnt_nxt,
  input  logic          rx_timeout,
  input  logic [CW-1:0] tx_cnt,
  input  logic          tx_full,
  output logic          rxrdy_n,
  output logic          txrdy_n
);

  logic blk_on;
  logic hold_q, hold_d;

  assign blk_on = en & blk;

  // block-mode receive hold: set at trigger or timeout, released on empty
  always_comb begin
    if (!blk_on)                  hold_d = 1'b0;
    else if (rx_cnt_nxt == '0)    hold_d = 1'b0;
    else if (hold_q || rx_timeout || (rx_cnt_nxt >= trig)) hold_d = 1'b1;
    else                          hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    if (blk_on) begin
      rxrdy_n = ~hold_q;
      txrdy_n = tx_full;
    end else begin
      rxrdy_n = (rx_cnt == '0);
      txrdy_n = (tx_cnt != '0);
    end
  end

endmodule

// File: rtl/uart_fifo_rdy.sv
`timescale 1ns/1ps
module uart_fifo_rdy
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_rd,
  output logic [DW-1:0]    host_rdata,
  input  logic             rxs_valid,
  input  logic [DW-1:0]    rxs_data,
  output logic             rxs_ready,
  output logic             txs_valid,
  output logic [DW-1:0]    txs_data,
  input  logic             txs_ready,
  input  logic             rx_timeout,
  output logic             rxrdy_n,
  output logic             txrdy_n,
  output logic             err_tx_ovf,
  output logic             err_rx_unf
);

  rdy_cfg_t      cfg_q;
  logic          en_flip, clr_rx, clr_tx;
  logic [CW-1:0] cap, trig;
  logic [CW-1:0] rx_cnt, rx_cnt_nxt, tx_cnt, tx_cnt_nxt;
  logic          rx_full, rx_empty, tx_full, tx_empty;

  assign en_flip = cfg_wr && (cfg_data[CFG_EN_BIT] != cfg_q.en);
  assign clr_rx  = (cfg_wr && cfg_data[CFG_CLRRX_BIT]) || en_flip;
  assign clr_tx  = (cfg_wr && cfg_data[CFG_CLRTX_BIT]) || en_flip;
  assign cap     = cfg_q.en ? CW'(DEPTH) : CW'(1);
  assign trig    = CW'(trig_bytes(cfg_q.trig_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q.en       <= cfg_data[CFG_EN_BIT];
      cfg_q.blk      <= cfg_data[CFG_BLK_BIT];
      cfg_q.trig_sel <= cfg_data[CFG_TRG_LSB +: 2];
    end
  end

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .cap(cap),
    .push(rxs_valid), .push_data(rxs_data),
    .pop(host_rd), .clr(clr_rx),
    .head(host_rdata), .cnt(rx_cnt), .cnt_nxt(rx_cnt_nxt),
    .full(rx_full), .empty(rx_empty)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n), .cap(cap),
    .push(host_wr), .push_data(host_wdata),
    .pop(txs_ready), .clr(clr_tx),
    .head(txs_data), .cnt(tx_cnt), .cnt_nxt(tx_cnt_nxt),
    .full(tx_full), .empty(tx_empty)
  );

  assign rxs_ready = !rx_full;
  assign txs_valid = !tx_empty;

  rdy_ctrl #(.CW(CW)) u_rdy (
    .clk(clk), .rst_n(rst_n),
    .en(cfg_q.en), .blk(cfg_q.blk), .trig(trig),
    .rx_cnt(rx_cnt), .rx_cnt_nxt(rx_cnt_nxt), .rx_timeout(rx_timeout),
    .tx_cnt(tx_cnt), .tx_full(tx_full),
    .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_tx_ovf <= 1'b0;
      err_rx_unf <= 1'b0;
    end else begin
      if (host_wr && tx_full)  err_tx_ovf <= 1'b1;
      if (host_rd && rx_empty) err_rx_unf <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_fifo_rdy_chk.sv
`timescale 1ns/1ps
module uart_fifo_rdy_chk #(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [5:0]    cfg_data,
  input logic          host_wr,
  input logic          host_rd,
  input logic          en,
  input logic          blk,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          rxrdy_n,
  input logic          txrdy_n,
  input logic          err_tx_ovf,
  input logic          err_rx_unf
);

  logic          blk_on;
  logic [CW-1:0] cap_c;
  assign blk_on = en && blk;
  assign cap_c  = en ? CW'(DEPTH) : CW'(1);

  AST_DIS_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (rx_cnt <= CW'(1)) && (tx_cnt <= CW'(1))); // R2
  AST_SC_RX_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !blk) |-> (rxrdy_n == (rx_cnt == '0))); // R3
  AST_BLK_EMPTY_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_on && rx_cnt == '0) |-> rxrdy_n); // R4
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_on && $past(blk_on) && !$past(rxrdy_n) && rx_cnt != '0) |-> !rxrdy_n); // R4
  AST_BLK_TX_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_on |-> (txrdy_n == (tx_cnt == CW'(DEPTH)))); // R6
  AST_CLR_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_data[1]) |=> (rx_cnt == '0) && rxrdy_n); // R7
  AST_CLR_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_data[2]) |=> (tx_cnt == '0) && !txrdy_n); // R7
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && tx_cnt == cap_c) |=> err_tx_ovf); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_tx_ovf |=> err_tx_ovf); // R8
  AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && rx_cnt == '0) |=> err_rx_unf); // R9
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_rx_unf |=> err_rx_unf); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH))); // R10
  AST_ENTER_BLK: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_on && !($past(en) && $past(blk))) |-> rxrdy_n); // R11

endmodule

bind uart_fifo_rdy uart_fifo_rdy_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
  .host_wr(host_wr), .host_rd(host_rd),
  .en(cfg_q.en), .blk(cfg_q.blk), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n),
  .err_tx_ovf(err_tx_ovf), .err_rx_unf(err_rx_unf)
);

// File: tb/sim_uart_fifo_rdy.sv
`timescale 1ns/1ps
module sim_uart_fifo_rdy;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cfg_wr = 0, host_wr = 0, host_rd = 0, rxs_valid = 0, txs_ready = 0, rx_timeout = 0;
  logic [5:0] cfg_data = 0;
  logic [7:0] host_wdata = 0, rxs_data = 0;
  logic [7:0] host_rdata, txs_data;
  logic       rxs_ready, txs_valid, rxrdy_n, txrdy_n, err_tx_ovf, err_rx_unf;

  uart_fifo_rdy u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .rxs_valid(rxs_valid), .rxs_data(rxs_data), .rxs_ready(rxs_ready),
    .txs_valid(txs_valid), .txs_data(txs_data), .txs_ready(txs_ready),
    .rx_timeout(rx_timeout), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n),
    .err_tx_ovf(err_tx_ovf), .err_rx_unf(err_rx_unf)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // pending stimulus for the next tick
  logic       p_cw = 0, p_hw = 0, p_hr = 0, p_rv = 0, p_tr = 0, p_to = 0;
  logic [5:0] p_cd = 0;
  logic [7:0] p_hwd = 0, p_rd = 0;

  // reference model
  byte unsigned rxq[$];
  byte unsigned txq[$];
  bit m_en = 0, m_blk = 0, m_hold = 0, m_eo = 0, m_eu = 0;
  int m_sel = 0;

  function automatic int lvl(input int s);
    if (s == 0) return 8;
    if (s == 1) return 16;
    if (s == 2) return 56;
    return 60;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int capm = m_en ? 128 : 1;
    bit bm = m_en && m_blk;
    bit erx = bm ? !m_hold : (rxq.size() == 0);
    bit etx = bm ? (txq.size() == capm) : (txq.size() != 0);
    string trx = !m_en ? "R2" : (m_blk ? "R4" : "R3");
    string ttx = !m_en ? "R2" : (m_blk ? "R6" : "R3");
    check(rxrdy_n == erx, trx, "rxrdy_n", rxrdy_n, erx);
    check(txrdy_n == etx, ttx, "txrdy_n", txrdy_n, etx);
    check(rxs_ready == (rxq.size() < capm), "R10", "rxs_ready", rxs_ready, rxq.size() < capm);
    check(txs_valid == (txq.size() != 0), "R10", "txs_valid", txs_valid, txq.size() != 0);
    if (rxq.size() != 0) check(host_rdata == rxq[0], "R10", "host_rdata", host_rdata, rxq[0]);
    if (txq.size() != 0) check(txs_data == txq[0], "R10", "txs_data", txs_data, txq[0]);
    check(err_tx_ovf == m_eo, "R8", "err_tx_ovf", err_tx_ovf, m_eo);
    check(err_rx_unf == m_eu, "R9", "err_rx_unf", err_rx_unf, m_eu);
  endtask

  task automatic model_step();
    int capm = m_en ? 128 : 1;
    bit bm = m_en && m_blk;
    int rs = rxq.size(), ts = txq.size();
    bit crx, ctx;
    if (p_hr) begin if (rs == 0) m_eu = 1; else void'(rxq.pop_front()); end
    if (p_rv && rs < capm) rxq.push_back(p_rd);
    if (p_hw) begin if (ts >= capm) m_eo = 1; else txq.push_back(p_hwd); end
    if (p_tr && ts != 0) void'(txq.pop_front());
    crx = p_cw && (p_cd[1] || (p_cd[0] != m_en));
    ctx = p_cw && (p_cd[2] || (p_cd[0] != m_en));
    if (crx) rxq.delete();
    if (ctx) txq.delete();
    if (!bm || rxq.size() == 0) m_hold = 0;
    else if (m_hold || p_to || rxq.size() >= lvl(m_sel)) m_hold = 1;
    if (p_cw) begin m_en = p_cd[0]; m_blk = p_cd[3]; m_sel = int'(p_cd[5:4]); end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    cfg_wr = p_cw; cfg_data = p_cd; host_wr = p_hw; host_wdata = p_hwd; host_rd = p_hr;
    rxs_valid = p_rv; rxs_data = p_rd; txs_ready = p_tr; rx_timeout = p_to;
    model_step();
    p_cw = 0; p_cd = 0; p_hw = 0; p_hr = 0; p_rv = 0; p_tr = 0; p_to = 0;
  endtask

  task automatic peek();
    @(posedge clk); #1;
  endtask

  task automatic push_rx(input int n);
    for (int i = 0; i < n; i++) begin p_rv = 1; p_rd = 8'($urandom); tick(); end
  endtask
  task automatic read_rx(input int n);
    for (int i = 0; i < n; i++) begin p_hr = 1; tick(); end
  endtask
  task automatic cfg(input logic [5:0] v);
    p_cw = 1; p_cd = v; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    check(rxrdy_n == 1, "R1", "rxrdy_n", rxrdy_n, 1);
    check(txrdy_n == 0, "R1", "txrdy_n", txrdy_n, 0);
    check(rxs_ready == 1 && txs_valid == 0, "R1", "stream flags", {rxs_ready, txs_valid}, 2);
    check(!err_tx_ovf && !err_rx_unf, "R1", "error flags", {err_tx_ovf, err_rx_unf}, 0);

    // R2: queues disabled, one-byte holding
    push_rx(2); peek();
    check(rxrdy_n == 0 && rxs_ready == 0, "R2", "rx held", {rxrdy_n, rxs_ready}, 0);
    p_hw = 1; p_hwd = 8'h5A; tick(); peek();
    check(txrdy_n == 1, "R2", "txrdy_n held", txrdy_n, 1);
    p_hw = 1; p_hwd = 8'hA5; tick(); peek();
    check(err_tx_ovf == 1 && txs_data == 8'h5A, "R8", "overflow ignored", txs_data, 8'h5A);
    p_tr = 1; tick();
    read_rx(2); peek();
    check(err_rx_unf == 1 && rxrdy_n == 1, "R9", "underflow ignored", err_rx_unf, 1);

    // R3/R10: enabled, single-character mode, fill transmit to capacity
    cfg(6'h01);
    push_rx(5);
    for (int i = 0; i < 129; i++) begin p_hw = 1; p_hwd = 8'(i); tick(); end
    peek();
    check(txs_valid == 1 && txrdy_n == 1, "R3", "tx nonempty", txrdy_n, 1);
    for (int i = 0; i < 128; i++) begin p_tr = 1; tick(); end
    peek();
    check(txrdy_n == 0, "R3", "tx empty", txrdy_n, 0);
    read_rx(5);

    // R4: trigger levels with hold until empty
    for (int s = 0; s < 4; s++) begin
      cfg(6'(8'h0B | (s << 4)));
      push_rx(lvl(s) - 1); peek();
      check(rxrdy_n == 1, "R4", "below trigger", rxrdy_n, 1);
      push_rx(1); peek();
      check(rxrdy_n == 0, "R4", "at trigger", rxrdy_n, 0);
      read_rx(lvl(s) - 1); peek();
      check(rxrdy_n == 0, "R4", "hold while draining", rxrdy_n, 0);
      read_rx(1); peek();
      check(rxrdy_n == 1, "R4", "release on empty", rxrdy_n, 1);
    end

    // R5: timeout below trigger
    cfg(6'h0B);
    push_rx(3);
    p_to = 1; tick(); peek();
    check(rxrdy_n == 0, "R5", "timeout assert", rxrdy_n, 0);

    // R11: leave and re-enter block mode with bytes queued
    cfg(6'h01); peek();
    check(rxrdy_n == 0, "R11", "single mode next clock", rxrdy_n, 0);
    cfg(6'h09); peek();
    check(rxrdy_n == 1, "R11", "hold cleared on entry", rxrdy_n, 1);

    // R6: block-mode transmit line
    for (int i = 0; i < 127; i++) begin p_hw = 1; p_hwd = 8'($urandom); tick(); end
    peek();
    check(txrdy_n == 0, "R6", "one slot free", txrdy_n, 0);
    p_hw = 1; p_hwd = 8'h11; tick(); peek();
    check(txrdy_n == 1, "R6", "full", txrdy_n, 1);

    // R7: clear both queues
    cfg(6'h0F); peek();
    check(rxrdy_n == 1 && txrdy_n == 0 && !txs_valid, "R7", "cleared", {rxrdy_n, txrdy_n}, 2);
    push_rx(4);
    cfg(6'h00); peek();
    check(rxs_ready == 1 && rxrdy_n == 1, "R7", "enable change clears", rxrdy_n, 1);

    // random traffic across all modes
    for (int i = 0; i < 6000; i++) begin
      p_rv = ($urandom % 2) == 0; p_rd = 8'($urandom);
      p_hr = ($urandom % 5) < 2;
      p_hw = ($urandom % 5) < 2; p_hwd = 8'($urandom);
      p_tr = ($urandom % 5) < 2;
      p_to = ($urandom % 40) == 0;
      if (($urandom % 150) == 0) begin
        p_cw = 1;
        p_cd = 6'($urandom) & ((($urandom % 4) == 0) ? 6'h3F : 6'h39);
        if (($urandom % 4) != 0) p_cd[0] = 1'b1;
      end
      tick();
    end
    tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule